// File: doc/BRIEF.md
# Interval Timer with Pulse Output

This block is a down-counting interval timer with a reload latch and a timer-driven output pin. Software loads the low half of the latch first. Writing the high half then copies the full latch value into the counter and starts it. While the counter runs it counts down once per clock. When it passes zero it raises an interrupt flag. Two bits of a control byte decide what happens next.

The continuous bit picks between two modes. In one-shot mode the timer stops after a single underflow. In free-running mode the counter spends one cycle reloading from the latch and then counts down again. The pin-control bit hands the top bit of an output port to the timer. The timer drives that pin low when it starts and inverts it on every underflow. When pin control is switched off, the timer's pin level returns high and the port's ordinary value appears on the pin.

Host bus decoding, the port data and direction registers and interrupt enabling are outside this block. The block takes write strobes and one read strobe from a decoder. It also takes the port's own bit 7 value from the port logic.

Top module: `intv_timer`

## Requirements
- R1: After reset the flag reads 0, the timer is stopped, the counter is 0, both control bits are 0 and the timer's pin level is high.
- R2: A strobe on `wr_cnt_hi` does three things on that clock edge. It stores the data byte as the latch high byte, loads the counter with {data byte, latch low byte} and starts the timer.
- R3: While the timer runs, no reload is pending and the counter is non-zero, the counter drops by one on every clock.
- R4: An underflow happens on a clock edge where the timer runs, no reload is pending and the counter is 0, and no high-byte write takes place on that edge. On that edge the counter becomes all ones and the flag is set. For a loaded value N, the flag therefore first reads 1 after N+1 clocks.
- R5: In one-shot mode (control byte bit 6 = 0), the timer stops on the underflow edge and the counter holds all ones. The flag is not set again until the next high-byte write.
- R6: In continuous mode (bit 6 = 1), the edge after an underflow loads the counter from the latch instead of decrementing. Underflows repeat every N+2 clocks.
- R7: A high-byte write made while pin control (bit 7) is 1 drives the timer's pin level low.
- R8: Each underflow with bit 7 = 1 inverts the timer's pin level.
- R9: A control write with bit 7 = 0 forces the timer's pin level high. This takes priority over an underflow on the same edge.
- R10: `port_b7_o` shows the timer's pin level when bit 7 = 1, and `port_b7_norm` otherwise.
- R11: A strobe on `rd_cnt_lo` clears the flag. An underflow on the same edge wins, and the flag stays 1.
- R12: A `wr_lat_lo` strobe changes only the latch low byte. The counter is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Write data byte shared by all write strobes |
| wr_lat_lo | input | 1 | Write strobe for the latch low byte |
| wr_cnt_hi | input | 1 | Write strobe for the high byte; loads and starts the timer |
| wr_ctrl | input | 1 | Write strobe for the control byte (bit 7 pin control, bit 6 continuous) |
| rd_cnt_lo | input | 1 | Read strobe for the counter low byte; clears the flag |
| port_b7_norm | input | 1 | Port bit 7 value from the ordinary port logic |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Timer is running |
| irq_o | output | 1 | Underflow interrupt flag |
| port_b7_o | output | 1 | Final port bit 7 pin level |

## Verification
Directed runs cover both modes.
- One-shot with N=5 places the first underflow at N+1 clocks. It also shows that the counter then parks at all ones.
- Continuous with N=3 separates the single reload cycle from an ordinary decrement, so the period must come out at N+2.

Pin-control sequences show three things:
- the start level is low;
- the level inverts on each underflow;
- the forced-high level survives switching pin control off and back on.

A read strobe placed exactly on an underflow edge tells the set priority apart from the clear. Seeded random strobe traffic with small high bytes produces many underflows. It also produces colliding writes, and a bench model compares every output on every cycle.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
   // bit positions in the control byte that the timer decodes
   localparam int CTRL_PIN_BIT  = 7;
   localparam int CTRL_CONT_BIT = 6;

   typedef struct packed {
      logic pin_en;   // timer owns port bit 7
      logic cont;     // continuous reload mode
   } tmr_ctrl_t;

   localparam tmr_ctrl_t CTRL_RESET = '{pin_en: 1'b0, cont: 1'b0};
endpackage

// File: rtl/intv_timer_count.sv
module intv_timer_count
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int CNT_W    = 16,
   parameter int UF_STYLE = 0      // 0: zero compare, 1: borrow of a decrement
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              cont_mode,
   output logic [CNT_W-1:0]  count_q,
   output logic [CNT_W-1:0]  latch_q,
   output logic              running_q,
   output logic              reload_q,
   output logic              uf_evt
);
   localparam int HI_W = CNT_W - BYTE_W;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic at_zero;
   logic [CNT_W-1:0] dec_val;

   generate
      if (UF_STYLE == 0) begin : g_cmp
         assign at_zero = (count_q == '0);
         assign dec_val = count_q - ONE;
      end else begin : g_borrow
         logic [CNT_W:0] diff;
         assign diff    = {1'b0, count_q} - {1'b0, ONE};
         assign at_zero = diff[CNT_W];
         assign dec_val = diff[CNT_W-1:0];
      end
   endgenerate

   assign uf_evt = running_q & ~reload_q & at_zero & ~wr_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else begin
         if (wr_lo) latch_q[BYTE_W-1:0]     <= wr_data;
         if (wr_hi) latch_q[CNT_W-1:BYTE_W] <= wr_data[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q   <= '0;
         running_q <= 1'b0;
         reload_q  <= 1'b0;
      end else if (wr_hi) begin
         count_q   <= {wr_data[HI_W-1:0], latch_q[BYTE_W-1:0]};
         running_q <= 1'b1;
         reload_q  <= 1'b0;
      end else if (reload_q) begin
         count_q  <= latch_q;
         reload_q <= 1'b0;
      end else if (running_q) begin
         count_q <= dec_val;
         if (uf_evt) begin
            if (cont_mode) reload_q  <= 1'b1;
            else           running_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/intv_timer_pin.sv
module intv_timer_pin
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              pin_en,
   input  logic              uf_evt,
   input  logic              port_norm,
   output logic              pin_lvl,
   output logic              port_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)                                 pin_lvl <= 1'b1;
      else if (wr_ctrl && !wr_data[CTRL_PIN_BIT]) pin_lvl <= 1'b1;
      else if (wr_hi && pin_en)                   pin_lvl <= 1'b0;
      else if (uf_evt && pin_en)                  pin_lvl <= ~pin_lvl;
   end

   assign port_out = pin_en ? pin_lvl : port_norm;
endmodule

// File: rtl/intv_timer_flag.sv
module intv_timer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic uf_evt,
   input  logic rd_clr,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (uf_evt) flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
   end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int CNT_W    = 16,
   parameter int UF_STYLE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_lat_lo,
   input  logic              wr_cnt_hi,
   input  logic              wr_ctrl,
   input  logic              rd_cnt_lo,
   input  logic              port_b7_norm,
   output logic [CNT_W-1:0]  count_o,
   output logic              running_o,
   output logic              irq_o,
   output logic              port_b7_o
);
   generate
      if (BYTE_W <= CTRL_PIN_BIT) begin : g_bad_byte
         $error("BYTE_W must hold control bit %0d", CTRL_PIN_BIT);
      end
      if (CNT_W <= BYTE_W || CNT_W > 2 * BYTE_W) begin : g_bad_cnt
         $error("CNT_W must lie in (BYTE_W, 2*BYTE_W]");
      end
      if (UF_STYLE != 0 && UF_STYLE != 1) begin : g_bad_style
         $error("UF_STYLE must be 0 or 1");
      end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] latch_q;
   logic             reload_q;
   logic             uf_evt;
   logic             pin_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= CTRL_RESET;
      else if (wr_ctrl) ctrl_q <= '{pin_en: wr_data[CTRL_PIN_BIT], cont: wr_data[CTRL_CONT_BIT]};
   end

   intv_timer_count #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .UF_STYLE(UF_STYLE)) u_count (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lat_lo), .wr_hi(wr_cnt_hi), .wr_data(wr_data),
      .cont_mode(ctrl_q.cont), .count_q(count_o), .latch_q(latch_q),
      .running_q(running_o), .reload_q(reload_q), .uf_evt(uf_evt)
   );

   intv_timer_pin #(.BYTE_W(BYTE_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_hi(wr_cnt_hi), .wr_data(wr_data),
      .pin_en(ctrl_q.pin_en), .uf_evt(uf_evt), .port_norm(port_b7_norm),
      .pin_lvl(pin_lvl), .port_out(port_b7_o)
   );

   intv_timer_flag u_flag (
      .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .rd_clr(rd_cnt_lo), .flag_q(irq_o)
   );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk
   import intv_timer_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] wr_data,
   input logic              wr_cnt_hi,
   input logic              wr_ctrl,
   input logic [CNT_W-1:0]  count_o,
   input logic              running_o,
   input logic              irq_o,
   input logic [CNT_W-1:0]  latch_q,
   input logic              reload_q,
   input logic              uf_evt,
   input logic              pin_lvl,
   input logic              cont,
   input logic              pin_en
);
   localparam int HI_W = CNT_W - BYTE_W;

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_hi |=> running_o && count_o == {$past(wr_data[HI_W-1:0]), $past(latch_q[BYTE_W-1:0])});

   assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !reload_q && count_o != '0 && !wr_cnt_hi) |=> count_o == $past(count_o) - CNT_W'(1));

   assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt |=> irq_o && count_o == '1);

   assert_one_shot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt && !cont) |=> !running_o);

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_q && !wr_cnt_hi) |=> count_o == $past(latch_q) && running_o);

   assert_pin_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt && pin_en && !wr_ctrl) |=> pin_lvl != $past(pin_lvl));

   assert_pin_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wr_data[CTRL_PIN_BIT]) |=> pin_lvl);
endmodule

bind intv_timer intv_timer_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cnt_hi(wr_cnt_hi), .wr_ctrl(wr_ctrl),
   .count_o(count_o), .running_o(running_o), .irq_o(irq_o), .latch_q(latch_q),
   .reload_q(reload_q), .uf_evt(uf_evt), .pin_lvl(pin_lvl),
   .cont(ctrl_q.cont), .pin_en(ctrl_q.pin_en)
);

// File: tb/intv_timer_tb.sv
module intv_timer_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wr_lat_lo = 1'b0, wr_cnt_hi = 1'b0, wr_ctrl = 1'b0, rd_cnt_lo = 1'b0;
   logic        port_b7_norm = 1'b0;
   logic [15:0] count_o;
   logic        running_o, irq_o, port_b7_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   intv_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_lat_lo(wr_lat_lo), .wr_cnt_hi(wr_cnt_hi),
      .wr_ctrl(wr_ctrl), .rd_cnt_lo(rd_cnt_lo), .port_b7_norm(port_b7_norm),
      .count_o(count_o), .running_o(running_o), .irq_o(irq_o), .port_b7_o(port_b7_o)
   );

   // bench model built from the requirements
   logic [15:0] m_cnt, m_lat;
   logic m_run, m_rp, m_pin, m_flag, m_pen, m_cont;

   function automatic logic m_uf();
      return m_run && !m_rp && m_cnt == 16'h0 && !wr_cnt_hi;
   endfunction

   function automatic logic m_port();
      return m_pen ? m_pin : port_b7_norm;
   endfunction

   always @(posedge clk) begin
      logic uf;
      uf = m_uf();
      if (!rst_n) begin
         m_cnt = '0; m_lat = '0; m_run = 0; m_rp = 0; m_pin = 1; m_flag = 0; m_pen = 0; m_cont = 0;
      end else begin
         if (wr_ctrl && !wr_data[7])  m_pin = 1'b1;
         else if (wr_cnt_hi && m_pen) m_pin = 1'b0;
         else if (uf && m_pen)        m_pin = ~m_pin;
         if (uf)             m_flag = 1'b1;
         else if (rd_cnt_lo) m_flag = 1'b0;
         if (wr_cnt_hi) begin
            m_cnt = {wr_data, m_lat[7:0]}; m_run = 1; m_rp = 0;
         end else if (m_rp) begin
            m_cnt = m_lat; m_rp = 0;
         end else if (m_run) begin
            m_cnt = m_cnt - 16'd1;
            if (uf) begin
               if (m_cont) m_rp = 1; else m_run = 0;
            end
         end
         if (wr_lat_lo) m_lat[7:0]  = wr_data;
         if (wr_cnt_hi) m_lat[15:8] = wr_data;
         if (wr_ctrl) begin m_pen = wr_data[7]; m_cont = wr_data[6]; end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr_lo(input logic [7:0] d);
      wr_data = d; wr_lat_lo = 1; tick(1); wr_lat_lo = 0;
   endtask
   task automatic wr_hi(input logic [7:0] d);
      wr_data = d; wr_cnt_hi = 1; tick(1); wr_cnt_hi = 0;
   endtask
   task automatic wr_cf(input logic [7:0] d);
      wr_data = d; wr_ctrl = 1; tick(1); wr_ctrl = 0;
   endtask
   task automatic rd_lo();
      rd_cnt_lo = 1; tick(1); rd_cnt_lo = 0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 irq", irq_o, 0);
      chk("R1 running", running_o, 0);
      chk("R1 count", count_o, 0);
      port_b7_norm = 1; #1;
      chk("R10 norm passes", port_b7_o, 1);
      port_b7_norm = 0; #1;
      chk("R10 norm passes", port_b7_o, 0);

      // one-shot, N=5
      wr_lo(8'd5);
      chk("R12 count kept", count_o, 0);
      wr_cf(8'h80);
      chk("R10 timer level high", port_b7_o, 1);
      wr_hi(8'h00);
      chk("R2 load", count_o, 16'd5);
      chk("R2 running", running_o, 1);
      chk("R7 pin low", port_b7_o, 0);
      tick(4);
      chk("R3 decrement", count_o, 16'd1);
      tick(1);
      chk("R4 no flag yet", irq_o, 0);
      chk("R3 zero", count_o, 16'd0);
      tick(1);
      chk("R4 flag", irq_o, 1);
      chk("R4 wrap", count_o, 16'hFFFF);
      chk("R5 stopped", running_o, 0);
      chk("R8 toggle high", port_b7_o, 1);
      tick(10);
      chk("R5 count holds", count_o, 16'hFFFF);
      rd_lo();
      chk("R11 cleared", irq_o, 0);
      tick(5);
      chk("R5 no new flag", irq_o, 0);

      // continuous, N=3
      wr_cf(8'hC0);
      wr_lo(8'd3);
      wr_hi(8'h00);
      chk("R2 load cont", count_o, 16'd3);
      chk("R7 pin low cont", port_b7_o, 0);
      tick(3);
      chk("R3 reach zero", count_o, 16'd0);
      tick(1);
      chk("R4 wrap cont", count_o, 16'hFFFF);
      chk("R8 toggle 1", port_b7_o, 1);
      tick(1);
      chk("R6 reload", count_o, 16'd3);
      chk("R6 still running", running_o, 1);
      tick(3);
      chk("R6 period zero", count_o, 16'd0);
      tick(1);
      chk("R6 period wrap", count_o, 16'hFFFF);
      chk("R8 toggle 2", port_b7_o, 0);

      // pin forced high by control write with bit 7 clear
      wr_cf(8'h40);
      chk("R10 norm when off", port_b7_o, 0);
      port_b7_norm = 1; #1;
      chk("R10 norm when off", port_b7_o, 1);
      port_b7_norm = 0;
      wr_cf(8'hC0);
      chk("R9 forced high", port_b7_o, 1);
      chk("R6 count after reload", count_o, 16'd2);

      // flag set wins over read clear
      rd_lo();
      chk("R11 cleared again", irq_o, 0);
      tick(1);
      chk("R3 at zero", count_o, 16'd0);
      rd_lo();
      chk("R11 set wins", irq_o, 1);
      chk("R8 toggle 3", port_b7_o, 0);

      // seeded random traffic checked against the bench model
      for (int c = 0; c < 4000; c++) begin
         int r;
         r = $urandom % 100;
         wr_lat_lo = (r < 6);
         wr_cnt_hi = (r >= 6 && r < 9);
         wr_ctrl   = (r >= 9 && r < 12);
         rd_cnt_lo = (r >= 12 && r < 18) || ($urandom % 50 == 0);
         if (wr_cnt_hi)      wr_data = 8'($urandom % 3);
         else if (wr_lat_lo) wr_data = 8'($urandom % 16);
         else                wr_data = 8'($urandom);
         port_b7_norm = 1'($urandom);
         tick(1);
         chk("R3 count", count_o, m_cnt);
         chk("R5 running", running_o, m_run);
         chk("R11 flag", irq_o, m_flag);
         chk("R10 port", port_b7_o, m_port());
      end
      wr_lat_lo = 0; wr_cnt_hi = 0; wr_ctrl = 0; rd_cnt_lo = 0;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule